// File: doc/BRIEF.md
# Masked Interrupt Status and Clear Unit

This block gathers four event sources of an embedded controller into one host interrupt line. The sources are a halt event, two software-generated events and an external error. Each event pulse sets a sticky status bit. A status bit reaches the host line only if the matching bit is set in both the mask register and the destination-routing register. Software uses write-one-to-set and write-one-to-clear aliases to change the status and the mask, and it writes the destination register directly.

The external error also has its own status register. That register holds a valid flag and the error code captured with the most recent error. Software acknowledges the error by writing the register back with the valid bit cleared.

Register access uses a plain single-cycle port. A write completes at the clock edge where `wr_en` is high. A read is combinational from `rd_addr` and returns the register contents after the most recent edge. The block has no data stream, so it has no valid/ready handshake and never applies back-pressure.

Top module: `irq_agg_top`

## Requirements
- R1: After reset every register reads zero, so all interrupts are masked, and `irq_o` is low.
- R2: An event pulse sets its status bit at the next clock edge. The bit positions are 0 for halt, 1 for software event 0, 2 for software event 1 and 3 for external error. The status register is read at address 0.
- R3: A status bit stays set, however many cycles pass, until software clears it.
- R4: Writing to address 2 clears every status bit written as one. If an event pulse for a bit arrives in the same cycle as a clear of that bit, the event wins and the bit stays set.
- R5: Writing to address 1 sets every status bit written as one. Bits written as zero are left unchanged.
- R6: Writing to address 4 sets mask bits. Writing to address 5 clears mask bits. Both act only on the bits written as one. The mask is read at address 3.
- R7: The destination register at address 6 takes the full value written and reads it back.
- R8: `irq_o` is high exactly while the bitwise AND of status, mask and destination is non-zero.
- R9: The external-error register at address 7 holds the valid flag in bit 0 and the code in bits 8:1. An external-error pulse sets the flag and captures `ext_err_code`. A write with bit 0 at zero clears the flag and leaves the code unchanged. A write can never set the flag.
- R10: Writes to address 0 are ignored, and the four alias addresses 1, 2, 4 and 5 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_halt | input | 1 | Halt event pulse |
| evt_sw0 | input | 1 | Software event 0 pulse |
| evt_sw1 | input | 1 | Software event 1 pulse |
| evt_ext_err | input | 1 | External error event pulse |
| ext_err_code | input | 8 | Error code captured with an external error |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 32 | Register read data |
| irq_o | output | 1 | Host interrupt line |

## Verification
The assertions check the following on every cycle:
- each event sets its status bit;
- set status bits stay sticky unless a clear arrives;
- the mask aliases set and clear the intended bits;
- the external-error flag follows its event and its acknowledge write;
- the host line stays low while the mask or the destination is zero.

Only the bench scenarios show the rest: the bitwise combination of the three registers that drives the line, the event-over-clear race, the code being kept after acknowledge, and the ignored writes and zero reads of the alias addresses.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int NUM_SRC = 4;
  localparam int ADDR_W  = 3;
  localparam int DATA_W  = 32;
  localparam int CODE_W  = 8;

  localparam int BIT_HALT = 0;
  localparam int BIT_SW0  = 1;
  localparam int BIT_SW1  = 2;
  localparam int BIT_EXT  = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_STAT     = 3'd0,
    A_STAT_SET = 3'd1,
    A_STAT_CLR = 3'd2,
    A_MASK     = 3'd3,
    A_MASK_SET = 3'd4,
    A_MASK_CLR = 3'd5,
    A_DEST     = 3'd6,
    A_EXT      = 3'd7
  } reg_addr_e;
endpackage

// File: rtl/irq_status_reg.sv
module irq_status_reg #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] evt,
  input  logic         set_we,
  input  logic         clr_we,
  input  logic [N-1:0] wdata,
  output logic [N-1:0] status_o
);
  logic [N-1:0] q;
  logic [N-1:0] set_bits;
  logic [N-1:0] clr_bits;

  assign set_bits = evt | (set_we ? wdata : '0);
  assign clr_bits = clr_we ? wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= (q & ~clr_bits) | set_bits;
  end

  assign status_o = q;

  for (genvar i = 0; i < N; i++) begin : g_chk
    // R2
    evt_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(evt[i]) |-> q[i]);
    // R3
    sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(q[i]) && !$past(clr_we && wdata[i])) |-> q[i]);
    // R5
    sw_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(set_we && wdata[i]) |-> q[i]);
  end
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_we,
  input  logic         clr_we,
  input  logic         dest_we,
  input  logic [N-1:0] wdata,
  output logic [N-1:0] mask_o,
  output logic [N-1:0] dest_o
);
  logic [N-1:0] mask_q;
  logic [N-1:0] dest_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      dest_q <= '0;
    end else begin
      if (set_we)       mask_q <= mask_q | wdata;
      else if (clr_we)  mask_q <= mask_q & ~wdata;
      if (dest_we)      dest_q <= wdata;
    end
  end

  assign mask_o = mask_q;
  assign dest_o = dest_q;

  for (genvar i = 0; i < N; i++) begin : g_chk
    // R6
    mask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(set_we && wdata[i]) |-> mask_q[i]);
    // R6
    mask_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(clr_we && !set_we && wdata[i]) |-> !mask_q[i]);
    // R6
    mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!set_we && !clr_we) |-> (mask_q[i] == $past(mask_q[i])));
  end
endmodule

// File: rtl/irq_ext_err.sv
module irq_ext_err #(
  parameter int CODE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt,
  input  logic [CODE_W-1:0] code_in,
  input  logic              wr_we,
  input  logic              wr_valid,
  output logic              valid_o,
  output logic [CODE_W-1:0] code_o
);
  logic              valid_q;
  logic [CODE_W-1:0] code_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      code_q  <= '0;
    end else if (evt) begin
      valid_q <= 1'b1;
      code_q  <= code_in;
    end else if (wr_we) begin
      valid_q <= valid_q & wr_valid;
    end
  end

  assign valid_o = valid_q;
  assign code_o  = code_q;

  // R9
  ext_valid_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(evt) |-> valid_q);
  // R9
  ext_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_we && !wr_valid && !evt) |-> !valid_q);
  // R9
  ext_no_wr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!evt) && !$past(valid_q)) |-> !valid_q);
  // R9
  ext_code_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!evt) |-> $stable(code_q));
endmodule

// File: rtl/irq_agg_top.sv
module irq_agg_top
  import irq_agg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_halt,
  input  logic              evt_sw0,
  input  logic              evt_sw1,
  input  logic              evt_ext_err,
  input  logic [CODE_W-1:0] ext_err_code,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq_o
);
  localparam int EXT_W = CODE_W + 1;

  logic [NUM_SRC-1:0] evt_vec;
  logic [NUM_SRC-1:0] status_q;
  logic [NUM_SRC-1:0] mask_q;
  logic [NUM_SRC-1:0] dest_q;
  logic               ext_valid;
  logic [CODE_W-1:0]  ext_code;
  logic               we_sset, we_sclr, we_mset, we_mclr, we_dest, we_ext;
  logic               unused_wr_hi;

  always_comb begin
    evt_vec           = '0;
    evt_vec[BIT_HALT] = evt_halt;
    evt_vec[BIT_SW0]  = evt_sw0;
    evt_vec[BIT_SW1]  = evt_sw1;
    evt_vec[BIT_EXT]  = evt_ext_err;
  end

  assign we_sset = wr_en && (wr_addr == A_STAT_SET);
  assign we_sclr = wr_en && (wr_addr == A_STAT_CLR);
  assign we_mset = wr_en && (wr_addr == A_MASK_SET);
  assign we_mclr = wr_en && (wr_addr == A_MASK_CLR);
  assign we_dest = wr_en && (wr_addr == A_DEST);
  assign we_ext  = wr_en && (wr_addr == A_EXT);
  assign unused_wr_hi = ^wr_data[DATA_W-1:NUM_SRC];

  irq_status_reg #(.N(NUM_SRC)) u_status (
    .clk(clk), .rst_n(rst_n), .evt(evt_vec),
    .set_we(we_sset), .clr_we(we_sclr),
    .wdata(wr_data[NUM_SRC-1:0]), .status_o(status_q)
  );

  irq_mask_reg #(.N(NUM_SRC)) u_mask (
    .clk(clk), .rst_n(rst_n), .set_we(we_mset), .clr_we(we_mclr),
    .dest_we(we_dest), .wdata(wr_data[NUM_SRC-1:0]),
    .mask_o(mask_q), .dest_o(dest_q)
  );

  irq_ext_err #(.CODE_W(CODE_W)) u_ext (
    .clk(clk), .rst_n(rst_n), .evt(evt_ext_err), .code_in(ext_err_code),
    .wr_we(we_ext), .wr_valid(wr_data[0]),
    .valid_o(ext_valid), .code_o(ext_code)
  );

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      A_STAT:  rd_data[NUM_SRC-1:0] = status_q;
      A_MASK:  rd_data[NUM_SRC-1:0] = mask_q;
      A_DEST:  rd_data[NUM_SRC-1:0] = dest_q;
      A_EXT:   rd_data[EXT_W-1:0]   = {ext_code, ext_valid};
      default: rd_data = '0;
    endcase
  end

  assign irq_o = |(status_q & mask_q & dest_q);

  // R8
  masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |-> !irq_o);
  // R8
  unrouted_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dest_q == '0) |-> !irq_o);
  // R10
  alias_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr == A_STAT_SET || rd_addr == A_MASK_CLR) |-> (rd_data == '0));
endmodule

// File: tb/tb_irq_agg_top.sv
`timescale 1ns/1ps
module tb_irq_agg_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        evt_halt = 0, evt_sw0 = 0, evt_sw1 = 0, evt_ext_err = 0;
  logic [7:0]  ext_err_code = 0;
  logic        wr_en = 0;
  logic [2:0]  wr_addr = 0;
  logic [31:0] wr_data = 0;
  logic [2:0]  rd_addr = 0;
  logic [31:0] rd_data;
  logic        irq_o;
  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  always #5 clk = ~clk;

  irq_agg_top dut (
    .clk(clk), .rst_n(rst_n), .evt_halt(evt_halt), .evt_sw0(evt_sw0),
    .evt_sw1(evt_sw1), .evt_ext_err(evt_ext_err), .ext_err_code(ext_err_code),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .irq_o(irq_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // Inputs change at falling edges; the register update happens at the next rising edge.
  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    step();
    wr_en = 0; wr_data = 0;
  endtask

  task automatic rd_chk(input string req, input logic [2:0] a, input logic [31:0] exp);
    rd_addr = a;
    #1;
    chk(req, rd_data, exp);
  endtask

  task automatic t_reset();
    for (int a = 0; a < 8; a++) rd_chk("R1 reset reg", 3'(a), 32'h0);
    chk("R1 reset irq", {31'b0, irq_o}, 32'h0);
  endtask

  task automatic t_events();
    evt_halt = 1; step(); evt_halt = 0;
    rd_chk("R2 halt bit0", 3'd0, 32'h1);
    evt_sw1 = 1; step(); evt_sw1 = 0;
    rd_chk("R2 sw1 bit2", 3'd0, 32'h5);
    evt_sw0 = 1; step(); evt_sw0 = 0;
    rd_chk("R2 sw0 bit1", 3'd0, 32'h7);
    for (int i = 0; i < 10; i++) step();
    rd_chk("R3 sticky", 3'd0, 32'h7);
    chk("R8 masked no irq", {31'b0, irq_o}, 32'h0);
  endtask

  task automatic t_clear();
    wr(3'd2, 32'h5);
    rd_chk("R4 w1c", 3'd0, 32'h2);
    evt_halt = 1; wr_en = 1; wr_addr = 3'd2; wr_data = 32'h1;
    step();
    evt_halt = 0; wr_en = 0; wr_data = 0;
    rd_chk("R4 event wins over clear", 3'd0, 32'h3);
    wr(3'd2, 32'hF);
    rd_chk("R4 clear all", 3'd0, 32'h0);
  endtask

  task automatic t_swset();
    wr(3'd1, 32'h6);
    rd_chk("R5 w1s", 3'd0, 32'h6);
    wr(3'd1, 32'h0);
    rd_chk("R5 zeros no effect", 3'd0, 32'h6);
    wr(3'd0, 32'hF);
    rd_chk("R10 stat write ignored", 3'd0, 32'h6);
    rd_chk("R10 alias1 reads zero", 3'd1, 32'h0);
    rd_chk("R10 alias2 reads zero", 3'd2, 32'h0);
  endtask

  task automatic t_mask();
    wr(3'd4, 32'hB);
    rd_chk("R6 mask set", 3'd3, 32'hB);
    wr(3'd5, 32'h1);
    rd_chk("R6 mask clr", 3'd3, 32'hA);
    rd_chk("R10 alias4 reads zero", 3'd4, 32'h0);
    rd_chk("R10 alias5 reads zero", 3'd5, 32'h0);
  endtask

  task automatic t_dest_irq();
    wr(3'd6, 32'h1);
    rd_chk("R7 dest", 3'd6, 32'h1);
    chk("R8 no overlap", {31'b0, irq_o}, 32'h0);
    wr(3'd6, 32'h3);
    rd_chk("R7 dest rewrite", 3'd6, 32'h3);
    chk("R8 bit1 routed", {31'b0, irq_o}, 32'h1);
    wr(3'd5, 32'h2);
    chk("R8 unmasked drop", {31'b0, irq_o}, 32'h0);
    wr(3'd4, 32'h2);
    chk("R8 remasked", {31'b0, irq_o}, 32'h1);
    wr(3'd2, 32'h2);
    chk("R8 status cleared", {31'b0, irq_o}, 32'h0);
    wr(3'd2, 32'hF);
  endtask

  task automatic t_ext();
    ext_err_code = 8'h5A; evt_ext_err = 1; step(); evt_ext_err = 0; ext_err_code = 0;
    rd_chk("R9 ext capture", 3'd7, 32'hB5);
    rd_chk("R2 ext bit3", 3'd0, 32'h8);
    wr(3'd7, 32'h0);
    rd_chk("R9 ack keeps code", 3'd7, 32'hB4);
    wr(3'd7, 32'h1);
    rd_chk("R9 write cannot set", 3'd7, 32'hB4);
    wr(3'd4, 32'h8); wr(3'd6, 32'h8);
    chk("R8 ext routed", {31'b0, irq_o}, 32'h1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    step();
    t_reset();
    t_events();
    t_clear();
    t_swset();
    t_mask();
    t_dest_irq();
    t_ext();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1;
      n_chk++; n_err++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule